// File: doc/BRIEF.md
# Bulk OUT Packet Count Completion Interrupt

This block counts bulk OUT packets for a pair of DMA channels that share one programmed packet count. Firmware writes the count as two bytes. It then enables one channel while software handshake mode is selected. The block loads the count into a down counter when that channel's enable rises, and it decrements the counter on every packet-done strobe from the channel. When the count runs out, the block raises a stop request to the channel and marks that channel's completion interrupt pending. A pending interrupt stays set until firmware writes the interrupt vector register with that channel's selector.

Only one channel may carry a bulk OUT transfer at a time, so a single counter serves both channels. If both enables are high together, the block flags an error and runs neither channel. In hardware handshake mode the counter stays idle and no completion interrupt is raised. The block moves no data. All of its pins are plain control and status levels or strobes, so no valid/ready handshake and no back-pressure apply.

Top module: `bulk_pkt_irq`

## Requirements
- R1: After reset, `irq_pend`, `ch_stop` and `both_en_err` are all 0, and both count bytes are 0.
- R2: A write with `cnt_wr_lo` stores `cnt_wdata` as bits 7:0 of the count, and a write with `cnt_wr_hi` stores it as bits 15:8. A run uses the value held before the clock edge at which it starts.
- R3: In software mode (`sw_hs_mode`=1), a rising edge of `ch_en[i]` while the other enable is low starts a run of N = count packets. Sampled `pkt_done` strobes decrement N. `irq_pend[i]` and `ch_stop[i]` rise in the cycle after the N-th strobe and not earlier.
- R4: A count of 0 sets `irq_pend[i]` and `ch_stop[i]` in the cycle after the enable edge, with no `pkt_done` needed.
- R5: With `sw_hs_mode`=0 the counter does not run: no `pkt_done` pattern sets `irq_pend` or `ch_stop`.
- R6: When both `ch_en` bits are sampled high, `both_en_err` is 1 in the next cycle, no channel starts, and a run in progress ends without an interrupt.
- R7: A sampled `vec_wr` with `vec_sel`=i (0 selects channel 0, 1 selects channel 1) clears `irq_pend[i]` in the next cycle. It leaves the other channel's pending bit and all `ch_stop` bits unchanged.
- R8: `ch_stop[i]` stays high until `ch_en[i]` is sampled low and clears in the cycle after that. At most one `ch_stop` bit is high at a time.
- R9: Dropping the active channel's enable before the count is used up ends the run. Later strobes raise no interrupt.
- R10: A completion and a vector clear for the same channel at the same edge leave `irq_pend` set.
- R11: `pkt_done` strobes while no run is active have no effect on the outputs.
- R12: Every start reloads the counter from the current count bytes, so a second run uses the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_wr_lo | input | 1 | Write strobe for the count low byte |
| cnt_wr_hi | input | 1 | Write strobe for the count high byte |
| cnt_wdata | input | 8 | Byte written to the count registers |
| ch_en | input | 2 | Per-channel enable; a rising edge starts a run |
| sw_hs_mode | input | 1 | 1 selects software handshake mode (counting active) |
| pkt_done | input | 1 | One-cycle strobe per bulk OUT packet handled by the active channel |
| vec_wr | input | 1 | Interrupt vector register write strobe |
| vec_sel | input | 1 | Channel whose completion interrupt the vector write clears |
| ch_stop | output | 2 | Per-channel stop request, held until the enable drops |
| irq_pend | output | 2 | Per-channel pending completion interrupt |
| both_en_err | output | 1 | Both enables seen high in the previous cycle |

## Verification
On every cycle, the assertions check the following. The counter stays idle in hardware mode and whenever both enables are high. A running counter is never zero. A newly pending interrupt always comes with its channel's stop request. At most one stop request is high. A vector write with no completion clears the selected pending bit. Only the bench scenarios can show the packet arithmetic: the exact cycle of completion for a given byte-pair count, the zero-count case, reloading with a new count, aborting a run by dropping the enable, and the clear-versus-set race.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int NUM_CH = 2;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int SEL_W  = $clog2(NUM_CH);
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/bpc_count_regs.sv
module bpc_count_regs
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output cnt_t              count
);
  logic [BYTE_W-1:0] lo_q, hi_q;

  // R2: two byte halves of the shared packet count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end
  end

  assign count = {hi_q, lo_q};
endmodule

// File: rtl/bpc_start_ctrl.sv
module bpc_start_ctrl
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              sw_hs,
  output logic              start_vld,
  output logic [SEL_W-1:0]  start_ch,
  output logic              both_en,
  output logic              both_en_err
);
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= '0;
      both_en_err <= 1'b0;
    end else begin
      en_q        <= ch_en;
      both_en_err <= both_en;
    end
  end

  assign rise      = ch_en & ~en_q;
  assign both_en   = &ch_en;
  assign start_vld = sw_hs && (|rise) && !both_en;

  always_comb begin
    start_ch = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rise[i]) start_ch = SEL_W'(i);
  end
endmodule

// File: rtl/bpc_pkt_counter.sv
module bpc_pkt_counter
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              sw_hs,
  input  logic              both_en,
  input  logic              start_vld,
  input  logic [SEL_W-1:0]  start_ch,
  input  cnt_t              load_val,
  input  logic              pkt_done,
  output logic [NUM_CH-1:0] done
);
  cnt_t             cnt_q;
  logic             active_q;
  logic [SEL_W-1:0] act_ch_q;
  logic             zero_start;
  logic             last_pkt;
  logic             halt;

  assign halt       = !sw_hs || both_en;
  assign zero_start = !halt && start_vld && (load_val == '0);
  assign last_pkt   = !halt && !start_vld && active_q && ch_en[act_ch_q]
                      && pkt_done && (cnt_q == cnt_t'(1));

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      done[i] = (zero_start && start_ch == SEL_W'(i)) ||
                (last_pkt && act_ch_q == SEL_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      act_ch_q <= '0;
    end else if (halt) begin
      active_q <= 1'b0;
    end else if (start_vld) begin
      act_ch_q <= start_ch;
      cnt_q    <= load_val;
      active_q <= (load_val != '0);
    end else if (active_q && !ch_en[act_ch_q]) begin
      active_q <= 1'b0;
    end else if (active_q && pkt_done) begin
      cnt_q    <= cnt_q - cnt_t'(1);
      if (cnt_q == cnt_t'(1)) active_q <= 1'b0;
    end
  end

  // R5
  hw_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_hs |=> !active_q);
  // R6
  both_en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    both_en |=> !active_q);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q != '0));
endmodule

// File: rtl/bpc_irq_regs.sv
module bpc_irq_regs
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] done,
  input  logic              vec_wr,
  input  logic [SEL_W-1:0]  vec_sel,
  output logic [NUM_CH-1:0] ch_stop,
  output logic [NUM_CH-1:0] irq_pend
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic clr;
    assign clr = vec_wr && (vec_sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_stop[i]  <= 1'b0;
        irq_pend[i] <= 1'b0;
      end else begin
        if (!ch_en[i])    ch_stop[i] <= 1'b0;
        else if (done[i]) ch_stop[i] <= 1'b1;
        // R10: a completion wins over a same-edge clear
        if (done[i])      irq_pend[i] <= 1'b1;
        else if (clr)     irq_pend[i] <= 1'b0;
      end
    end

    // R3
    irq_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend[i]) |-> ch_stop[i]);
    // R7
    vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !done[i]) |=> !irq_pend[i]);
  end

  // R8
  stop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_stop));
endmodule

// File: rtl/bulk_pkt_irq.sv
module bulk_pkt_irq
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr_lo,
  input  logic              cnt_wr_hi,
  input  logic [BYTE_W-1:0] cnt_wdata,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              sw_hs_mode,
  input  logic              pkt_done,
  input  logic              vec_wr,
  input  logic [SEL_W-1:0]  vec_sel,
  output logic [NUM_CH-1:0] ch_stop,
  output logic [NUM_CH-1:0] irq_pend,
  output logic              both_en_err
);
  cnt_t              count;
  logic              start_vld;
  logic [SEL_W-1:0]  start_ch;
  logic              both_en;
  logic [NUM_CH-1:0] done;

  bpc_count_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi),
    .wdata(cnt_wdata), .count(count)
  );

  bpc_start_ctrl u_start (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .sw_hs(sw_hs_mode),
    .start_vld(start_vld), .start_ch(start_ch), .both_en(both_en),
    .both_en_err(both_en_err)
  );

  bpc_pkt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .sw_hs(sw_hs_mode),
    .both_en(both_en), .start_vld(start_vld), .start_ch(start_ch),
    .load_val(count), .pkt_done(pkt_done), .done(done)
  );

  bpc_irq_regs u_irq (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .done(done),
    .vec_wr(vec_wr), .vec_sel(vec_sel), .ch_stop(ch_stop),
    .irq_pend(irq_pend)
  );
endmodule

// File: tb/bulk_pkt_irq_tb.sv
module bulk_pkt_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_wr_lo = 0, cnt_wr_hi = 0;
  logic [7:0] cnt_wdata = '0;
  logic [1:0] ch_en = '0;
  logic       sw_hs_mode = 1'b1;
  logic       pkt_done = 0;
  logic       vec_wr = 0;
  logic [0:0] vec_sel = '0;
  logic [1:0] ch_stop, irq_pend;
  logic       both_en_err;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  bulk_pkt_irq u_dut (.*);

  always #2 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_count(logic [15:0] v);
    cnt_wdata = v[7:0]; cnt_wr_lo = 1; step(); cnt_wr_lo = 0;
    cnt_wdata = v[15:8]; cnt_wr_hi = 1; step(); cnt_wr_hi = 0;
  endtask

  task automatic pulse_pkts(int n);
    for (int k = 0; k < n; k++) begin
      pkt_done = 1; step(); pkt_done = 0;
    end
  endtask

  task automatic cleanup();
    ch_en = '0; pkt_done = 0;
    vec_wr = 1; vec_sel = 0; step(); vec_sel = 1; step(); vec_wr = 0;
    step();
  endtask

  task automatic t_reset();
    check("R1 irq_pend", irq_pend, 0);
    check("R1 ch_stop", ch_stop, 0);
    check("R1 both_en_err", both_en_err, 0);
  endtask

  task automatic t_count_run(int ch, int n);
    set_count(16'(n));
    ch_en[ch] = 1; step();
    for (int k = 1; k <= n; k++) begin
      pkt_done = 1; step(); pkt_done = 0;
      if (k < n) check("R3 early irq", irq_pend, 0);
    end
    check("R3 irq after last packet", irq_pend, 2'b01 << ch);
    check("R3 stop after last packet", ch_stop, 2'b01 << ch);
    vec_wr = 1; vec_sel = 1'(ch); step(); vec_wr = 0;
    check("R7 vector clears irq", irq_pend, 0);
    check("R7 stop kept after clear", ch_stop, 2'b01 << ch);
    step();
    check("R8 stop held while enabled", ch_stop, 2'b01 << ch);
    ch_en[ch] = 0; step();
    check("R8 stop drops with enable", ch_stop, 0);
    cleanup();
  endtask

  task automatic t_two_byte();
    set_count(16'h0103);
    ch_en[0] = 1; step();
    pulse_pkts(258);
    check("R2 no irq before 259 packets", irq_pend, 0);
    pulse_pkts(1);
    check("R2 irq at 16-bit count 0x0103", irq_pend, 2'b01);
    cleanup();
  endtask

  task automatic t_zero();
    set_count(16'd0);
    ch_en[1] = 1; step();
    check("R4 zero count irq", irq_pend, 2'b10);
    check("R4 zero count stop", ch_stop, 2'b10);
    cleanup();
  endtask

  task automatic t_hw_mode();
    set_count(16'd2);
    sw_hs_mode = 0;
    ch_en[0] = 1; step();
    pulse_pkts(3);
    check("R5 hw mode irq", irq_pend, 0);
    check("R5 hw mode stop", ch_stop, 0);
    sw_hs_mode = 1;
    cleanup();
  endtask

  task automatic t_both();
    set_count(16'd1);
    ch_en = 2'b11; step();
    check("R6 error flag", both_en_err, 1);
    pulse_pkts(2);
    check("R6 no start irq", irq_pend, 0);
    cleanup();
    check("R6 error clears", both_en_err, 0);
    set_count(16'd3);
    ch_en[0] = 1; step();
    pulse_pkts(1);
    ch_en[1] = 1; step(); ch_en[1] = 0; step();
    pulse_pkts(3);
    check("R6 aborted run no irq", irq_pend, 0);
    cleanup();
  endtask

  task automatic t_abort();
    set_count(16'd2);
    ch_en[1] = 1; step();
    pulse_pkts(1);
    ch_en[1] = 0; step();
    pulse_pkts(2);
    check("R9 abort irq", irq_pend, 0);
    check("R9 abort stop", ch_stop, 0);
    cleanup();
  endtask

  task automatic t_race();
    set_count(16'd1);
    ch_en[0] = 1; step();
    pkt_done = 1; vec_wr = 1; vec_sel = 0; step();
    pkt_done = 0; vec_wr = 0;
    check("R10 set beats clear", irq_pend, 2'b01);
    cleanup();
  endtask

  task automatic t_idle();
    set_count(16'd1);
    pulse_pkts(3);
    check("R11 idle strobes irq", irq_pend, 0);
    check("R11 idle strobes stop", ch_stop, 0);
  endtask

  task automatic t_reload();
    set_count(16'd4);
    ch_en[0] = 1; step();
    pulse_pkts(4);
    check("R12 first run", irq_pend, 2'b01);
    cleanup();
    set_count(16'd2);
    ch_en[0] = 1; step();
    pulse_pkts(1);
    check("R12 second run early", irq_pend, 0);
    pulse_pkts(1);
    check("R12 second run uses new count", irq_pend, 2'b01);
    cleanup();
  endtask

  initial begin
    step(); step();
    t_reset();
    rst_n = 1; step();
    t_count_run(0, 3);
    t_count_run(1, 1);
    t_two_byte();
    t_zero();
    t_hw_mode();
    t_both();
    t_abort();
    t_race();
    t_idle();
    t_reload();
    done_flag = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done_flag; c++) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule